// File: doc/BRIEF.md
# Smart-Card Clock and Bit-Rate Generator

This block produces the clock driven onto a smart card and the bit timing used by a half-duplex, character-oriented (T=0) card link. A fast system clock (13 MHz in the target system) is divided by a fixed prescaler of four. The result is a 3.25 MHz card clock with equal high and low phases.

An elementary time unit (one bit period) is then counted out in card-clock cycles. The length of that unit is chosen from four divisors: 372, 64, 32 or 16. For each bit the block gives a one-cycle bit tick and a one-cycle sample strobe at mid-bit. The character framer and the receive logic consume these pulses.

The card clock can be gated off. When it is gated off, the clock parks low and all bit timing restarts. The divisor choice and the card supply-voltage choice are held in a small configuration register. That register accepts writes only while the interface power enable is low.

Top module: `sc_clkgen`

## Requirements
- R1: After reset, card_clk, etu_tick and smp_strobe are 0, div_sel reads 2'b00 and vsel reads 0.
- R2: While clk_en is 1, card_clk repeats a pattern of 2 system cycles low followed by 2 system cycles high (system clock divided by 4, 50% duty). The first system cycle after enabling is low.
- R3: div_sel encodes the bit-period divisor N as follows: 00 gives 372, 01 gives 64, 10 gives 32 and 11 gives 16. etu_tick is a single-cycle pulse that appears every 4*N system cycles. The first pulse comes 4*N cycles after enabling, and every pulse falls in a card-clock low phase.
- R4: smp_strobe is a single-cycle pulse at the middle of each bit period, 2*N system cycles after the start of the bit. It never coincides with etu_tick.
- R5: With pwr_en at 0, a cycle with cfg_we at 1 loads cfg_div into div_sel and cfg_vsel into vsel. The new values are visible on the next cycle.
- R6: With pwr_en at 1, a cfg_we write leaves div_sel, vsel and the bit period unchanged.
- R7: When clk_en is 0, card_clk is low from the next cycle on, both pulses stay 0, and the bit count resets. On re-enable, the first etu_tick comes a full 4*N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Card clock enable; 0 parks the clock low and clears bit timing |
| pwr_en | input | 1 | Interface powered; blocks configuration writes while 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 2 | Divisor code to write |
| cfg_vsel | input | 1 | Supply-voltage selection to write (0 low, 1 high) |
| card_clk | output | 1 | Clock to the card |
| etu_tick | output | 1 | One-cycle pulse at each bit boundary |
| smp_strobe | output | 1 | One-cycle mid-bit sample pulse |
| div_sel | output | 2 | Current divisor code |
| vsel | output | 1 | Current supply-voltage selection |

## Verification
The bench builds the block with its default parameters: a prescaler of four and divisors of 372, 64, 32 and 16. With these values, every divisor code can be run for several full bit periods well inside the cycle budget, including the longest 1488-cycle period. A reference model counts enabled system cycles and derives the card-clock level, tick and strobe from the active divisor. It tracks the configuration register from the write rule. Writes are tried in both power states, and the clock is gated off in the middle of a bit to check that timing restarts.

// File: rtl/sc_clkgen.sv
module sc_clkgen #(
  parameter int PRE_DIV = 4,
  parameter int DIV_0   = 372,
  parameter int DIV_1   = 64,
  parameter int DIV_2   = 32,
  parameter int DIV_3   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic       pwr_en,
  input  logic       cfg_we,
  input  logic [1:0] cfg_div,
  input  logic       cfg_vsel,
  output logic       card_clk,
  output logic       etu_tick,
  output logic       smp_strobe,
  output logic [1:0] div_sel,
  output logic       vsel
);
  localparam int PW   = $clog2(PRE_DIV);
  localparam int CW   = $clog2(DIV_0 + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(PRE_DIV - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(PRE_DIV / 2);

  logic [PW-1:0] ph, ph_nxt;
  logic [CW-1:0] cnt, etu_n, half_n;
  logic          card_end, cnt_wrap;

  always_comb begin
    case (div_sel)
      2'b00:   etu_n = CW'(DIV_0);
      2'b01:   etu_n = CW'(DIV_1);
      2'b10:   etu_n = CW'(DIV_2);
      default: etu_n = CW'(DIV_3);
    endcase
  end

  assign half_n   = etu_n >> 1;
  assign ph_nxt   = (ph == PH_LAST) ? '0 : ph + 1'b1;
  assign card_end = ph == PH_LAST;
  assign cnt_wrap = cnt >= etu_n - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= 2'b00;
      vsel    <= 1'b0;
    end else if (cfg_we && !pwr_en) begin
      div_sel <= cfg_div;
      vsel    <= cfg_vsel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= '0;
      cnt        <= '0;
      card_clk   <= 1'b0;
      etu_tick   <= 1'b0;
      smp_strobe <= 1'b0;
    end else if (!clk_en) begin
      ph         <= '0;
      cnt        <= '0;
      card_clk   <= 1'b0;
      etu_tick   <= 1'b0;
      smp_strobe <= 1'b0;
    end else begin
      ph         <= ph_nxt;
      card_clk   <= ph_nxt >= PH_HIGH;
      etu_tick   <= card_end && cnt_wrap;
      smp_strobe <= card_end && (cnt == half_n - 1'b1);
      if (card_end) cnt <= cnt_wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sc_clkgen_chk.sv
module sc_clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic       pwr_en,
  input logic       card_clk,
  input logic       etu_tick,
  input logic       smp_strobe,
  input logic [1:0] div_sel,
  input logic       vsel
);
  // R7
  clk_park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !card_clk && !etu_tick && !smp_strobe);
  // R4
  tick_strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(etu_tick && smp_strobe));
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |=> !etu_tick);
  // R3
  tick_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |-> !card_clk);
  // R6
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en |=> $stable(div_sel) && $stable(vsel));
  // R2
  clk_no_short_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && $rose(card_clk) |=> card_clk);
endmodule

bind sc_clkgen sc_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pwr_en(pwr_en),
  .card_clk(card_clk), .etu_tick(etu_tick), .smp_strobe(smp_strobe),
  .div_sel(div_sel), .vsel(vsel)
);

// File: tb/sc_clkgen_tb.sv
module sc_clkgen_tb;
  logic clk = 0, rst_n = 0, clk_en = 0, pwr_en = 0, cfg_we = 0, cfg_vsel = 0;
  logic [1:0] cfg_div = 0;
  logic card_clk, etu_tick, smp_strobe, vsel;
  logic [1:0] div_sel;

  int checks = 0, fails = 0;
  int c = 0, m_div = 0, m_vsel = 0, tick_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sc_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pwr_en(pwr_en),
    .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_vsel(cfg_vsel),
    .card_clk(card_clk), .etu_tick(etu_tick), .smp_strobe(smp_strobe),
    .div_sel(div_sel), .vsel(vsel)
  );

  function automatic int n_of(int code);
    case (code)
      0: return 372;
      1: return 64;
      2: return 32;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c = 0; m_div = 0; m_vsel = 0;
    end else begin
      if (cfg_we && !pwr_en) begin m_div = cfg_div; m_vsel = cfg_vsel; end
      c = clk_en ? c + 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int p;
      p = 4 * n_of(m_div);
      chk(card_clk == ((c % 4) >= 2), "R2 card_clk", card_clk, (c % 4) >= 2);
      chk(etu_tick == (c > 0 && c % p == 0), "R3 etu_tick", etu_tick, c > 0 && c % p == 0);
      chk(smp_strobe == (c % p == p / 2), "R4 smp_strobe", smp_strobe, c % p == p / 2);
      chk(div_sel == m_div, "R5/R6 div_sel", div_sel, m_div);
      chk(vsel == m_vsel, "R5/R6 vsel", vsel, m_vsel);
      if (etu_tick) tick_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int d, input bit v);
    cfg_div = d[1:0]; cfg_vsel = v; cfg_we = 1;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic run_div(input int d);
    clk_en = 0; pwr_en = 0;
    wr(d, d[0]);
    cyc(1);
    // R5 write accepted while unpowered
    chk(div_sel == d[1:0], "R5 div load", div_sel, d);
    pwr_en = 1; clk_en = 1; tick_cnt = 0;
    cyc(4 * n_of(d) * 3 + 1);
    // R3 tick count over three periods
    chk(tick_cnt == 3, "R3 tick count", tick_cnt, 3);
  endtask

  initial begin
    cyc(2);
    // R1 reset state
    chk(card_clk == 0 && etu_tick == 0 && smp_strobe == 0, "R1 outputs", card_clk, 0);
    chk(div_sel == 0 && vsel == 0, "R1 config", div_sel, 0);
    rst_n = 1;
    cyc(2);
    chk(card_clk == 0, "R1 idle clk", card_clk, 0);
    for (int d = 0; d < 4; d++) run_div(d);
    // R6 write while powered is ignored
    wr(2, 0);
    cyc(1);
    chk(div_sel == 2'b11, "R6 div held", div_sel, 3);
    chk(vsel == 1'b1, "R6 vsel held", vsel, 1);
    tick_cnt = 0;
    cyc(4 * 16 * 2);
    chk(tick_cnt == 2, "R6 period kept", tick_cnt, 2);
    // R7 gate mid-bit, then restart
    cyc(20);
    clk_en = 0;
    cyc(2);
    chk(card_clk == 0 && etu_tick == 0, "R7 parked", card_clk, 0);
    cyc(10);
    chk(card_clk == 0, "R7 still low", card_clk, 0);
    clk_en = 1; tick_cnt = 0;
    cyc(4 * 16 - 1);
    chk(tick_cnt == 0, "R7 no early tick", tick_cnt, 0);
    cyc(1);
    chk(etu_tick == 1, "R7 first tick", etu_tick, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule